// File: doc/BRIEF.md
# DMA Burst Beat Sequencer

This block turns one DMA command into the sequence of beats on a 64-bit data path. Each beat carries eight bytes, so every beat address is 8-byte aligned. A command gives a start address, a beat count and four flags: read, descending, wrapped-group and masked write. Once a command is taken, the sequencer emits one beat per clock. It pulses a start strobe on the first data beat and raises a last flag on the final one.

Three beat orders are supported. In ascending order the address rises by 8 each beat, and in descending order it falls by 8. In wrapped-group order the beat index is XORed into the low bits of the start beat number. This serves the requested word first and then wraps inside an aligned group of 2 or 4 beats. A masked write adds one lead cycle before the data beats, during which the write path carries the byte-enable mask. Memory arrays, refresh, bank decoding and data storage live outside this block.

The controller has three states:
- `ST_IDLE`: waiting for a command. It leaves on `go`, which is `cmd_valid` sampled while `busy` is low.
- `ST_MASK`: the single lead cycle of a masked write. It always moves on to `ST_BEAT`.
- `ST_BEAT`: one data beat per clock. It returns to `ST_IDLE` after the final beat, the `done` transition.

The transitions are named idle→mask (masked write accepted), idle→beat (any other command), mask→beat and beat→idle.

Top module: `dma_beat_seq`

## Requirements
- R1: A synchronous active-high `rst` returns the block to idle. In the cycle after `rst` is sampled high, `busy`, `beat_valid`, `beat_start`, `beat_last` and `mask_beat` are all low, even when reset arrives in the middle of a burst.
- R2: A command is taken only at a rising edge where `cmd_valid` is high and `busy` is low. A command presented while `busy` is high is ignored: the running burst keeps its addresses and length, and no further burst follows it.
- R3: In ascending order, data beat j (counting from 0) shows `beat_addr` = ((`cmd_addr` with bits [2:0] cleared) + 8·j) modulo 2^ADDR_W. Beats come on consecutive clocks, and the first data beat appears in the cycle after acceptance unless R8 adds a lead cycle.
- R4: With `cmd_down`=1 and `cmd_subblock`=0, data beat j shows `beat_addr` = (aligned start − 8·j) modulo 2^ADDR_W.
- R5: With `cmd_subblock`=1, data beat j shows `beat_addr` = (((`cmd_addr`>>3) XOR j) << 3) modulo 2^ADDR_W. The burst is 2 beats when `cmd_len` ≤ 2 and 4 beats otherwise, and `cmd_down` has no effect.
- R6: Outside wrapped-group order, a burst has `cmd_len` data beats for values 1 to 15, and a `cmd_len` of 0 gives one beat. `beat_valid` is low in the cycle after the final beat.
- R7: `beat_start` is high on data beat 0 only. `beat_last` is high only on the final data beat, exactly (beats−1) clocks after `beat_start`.
- R8: When `cmd_masked`=1 and `cmd_read`=0, the cycle after acceptance has `mask_beat`=1 and `beat_valid`=0, and data beat 0 follows in the next cycle. For reads `cmd_masked` is ignored and `mask_beat` stays low.
- R9: `busy` is high from the cycle after acceptance through the final data beat and low in the cycle after it. A new command can be accepted in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_addr | input | ADDR_W | Start byte address |
| cmd_len | input | LEN_W | Requested beat count |
| cmd_read | input | 1 | 1 = read burst, 0 = write burst |
| cmd_down | input | 1 | Descending order request |
| cmd_subblock | input | 1 | Wrapped-group order |
| cmd_masked | input | 1 | Masked write (lead mask cycle) |
| busy | output | 1 | Burst in progress |
| beat_valid | output | 1 | Data beat this cycle |
| beat_addr | output | ADDR_W | 8-byte-aligned beat address |
| beat_start | output | 1 | First data beat |
| beat_last | output | 1 | Final data beat |
| mask_beat | output | 1 | Byte-enable mask cycle of a masked write |

## Verification
The bench builds the block with ADDR_W=16 and LEN_W=4. The narrow address lets a descending burst from address zero wrap to the top of the space, and lets an ascending burst near 0xFFF0 wrap to zero, within a few beats. LEN_W=4 reaches the full 15-beat burst and the zero-length case, along with subblock lengths that are forced to 2 or 4.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MASK = 2'd1,
        ST_BEAT = 2'd2
    } seq_state_e;

    localparam int BEAT_SHIFT = 3;
endpackage

// File: rtl/dma_cmd_norm.sv
module dma_cmd_norm #(
    parameter int LEN_W = 4
) (
    input  logic [LEN_W-1:0] len_in,
    input  logic             sub_in,
    input  logic             down_in,
    input  logic             read_in,
    input  logic             masked_in,
    output logic [LEN_W-1:0] last_idx,
    output logic             down_eff,
    output logic             masked_eff
);
    logic [LEN_W-1:0] beats;

    always_comb begin
        if (sub_in) begin
            beats = (len_in <= LEN_W'(2)) ? LEN_W'(2) : LEN_W'(4);
        end else if (len_in == '0) begin
            beats = LEN_W'(1);
        end else begin
            beats = len_in;
        end
        last_idx   = beats - LEN_W'(1);
        down_eff   = down_in & ~sub_in;
        masked_eff = masked_in & ~read_in;
    end
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [LEN_W-1:0]  beat_idx,
    input  logic              down,
    input  logic              sub,
    output logic [ADDR_W-1:0] addr
);
    import dma_seq_pkg::*;
    localparam int IDX_W = ADDR_W - BEAT_SHIFT;

    logic [IDX_W-1:0] base_n;
    logic [IDX_W-1:0] step_n;
    logic [IDX_W-1:0] word_n;

    assign base_n = start_addr[ADDR_W-1:BEAT_SHIFT];
    assign step_n = IDX_W'(beat_idx);

    always_comb begin
        if (sub) begin
            word_n = base_n ^ step_n;
        end else if (down) begin
            word_n = base_n - step_n;
        end else begin
            word_n = base_n + step_n;
        end
        addr = {word_n, {BEAT_SHIFT{1'b0}}};
    end

    p_step_up_r3: assert property (@(posedge clk) disable iff (rst)
        (valid && $past(valid) && !sub && !down && $stable(start_addr))
        |-> addr == $past(addr) + ADDR_W'(8));

    p_step_down_r4: assert property (@(posedge clk) disable iff (rst)
        (valid && $past(valid) && !sub && down && $stable(start_addr))
        |-> addr == $past(addr) - ADDR_W'(8));

    p_group_held_r5: assert property (@(posedge clk) disable iff (rst)
        (valid && sub) |-> addr[ADDR_W-1:BEAT_SHIFT+2] == start_addr[ADDR_W-1:BEAT_SHIFT+2]);
endmodule

// File: rtl/dma_beat_fsm.sv
module dma_beat_fsm #(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic             masked,
    input  logic [LEN_W-1:0] last_idx,
    output logic [LEN_W-1:0] beat_idx,
    output logic             busy,
    output logic             beat_valid,
    output logic             beat_start,
    output logic             beat_last,
    output logic             mask_beat
);
    import dma_seq_pkg::*;

    seq_state_e state_q;
    logic [LEN_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    cnt_q <= '0;
                    if (go) begin
                        state_q <= masked ? ST_MASK : ST_BEAT;
                    end
                end
                ST_MASK: begin
                    state_q <= ST_BEAT;
                end
                ST_BEAT: begin
                    if (cnt_q == last_idx) begin
                        state_q <= ST_IDLE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + LEN_W'(1);
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        busy       = 1'b0;
        beat_valid = 1'b0;
        beat_start = 1'b0;
        beat_last  = 1'b0;
        mask_beat  = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_MASK: begin
                busy      = 1'b1;
                mask_beat = 1'b1;
            end
            ST_BEAT: begin
                busy       = 1'b1;
                beat_valid = 1'b1;
                beat_start = (cnt_q == '0);
                beat_last  = (cnt_q == last_idx);
            end
            default: ;
        endcase
        beat_idx = cnt_q;
    end

    p_start_once_r7: assert property (@(posedge clk) disable iff (rst)
        beat_start |=> !beat_start);

    p_last_in_beat_r7: assert property (@(posedge clk) disable iff (rst)
        beat_last |-> beat_valid);

    p_mask_lead_r8: assert property (@(posedge clk) disable iff (rst)
        mask_beat |=> (beat_start && beat_valid));

    p_busy_drop_r9: assert property (@(posedge clk) disable iff (rst)
        beat_last |=> !busy);
endmodule

// File: rtl/dma_beat_seq.sv
module dma_beat_seq #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic              cmd_read,
    input  logic              cmd_down,
    input  logic              cmd_subblock,
    input  logic              cmd_masked,
    output logic              busy,
    output logic              beat_valid,
    output logic [ADDR_W-1:0] beat_addr,
    output logic              beat_start,
    output logic              beat_last,
    output logic              mask_beat
);
    logic             go;
    logic [LEN_W-1:0] last_n;
    logic             down_n;
    logic             masked_n;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  last_q;
    logic              down_q;
    logic              sub_q;
    logic [LEN_W-1:0]  idx;

    assign go = cmd_valid & ~busy;

    dma_cmd_norm #(.LEN_W(LEN_W)) norm_i (
        .len_in     (cmd_len),
        .sub_in     (cmd_subblock),
        .down_in    (cmd_down),
        .read_in    (cmd_read),
        .masked_in  (cmd_masked),
        .last_idx   (last_n),
        .down_eff   (down_n),
        .masked_eff (masked_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            last_q <= '0;
            down_q <= 1'b0;
            sub_q  <= 1'b0;
        end else if (go) begin
            addr_q <= cmd_addr;
            last_q <= last_n;
            down_q <= down_n;
            sub_q  <= cmd_subblock;
        end
    end

    dma_beat_fsm #(.LEN_W(LEN_W)) fsm_i (
        .clk        (clk),
        .rst        (rst),
        .go         (go),
        .masked     (masked_n),
        .last_idx   (last_q),
        .beat_idx   (idx),
        .busy       (busy),
        .beat_valid (beat_valid),
        .beat_start (beat_start),
        .beat_last  (beat_last),
        .mask_beat  (mask_beat)
    );

    dma_addr_gen #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) agen_i (
        .clk        (clk),
        .rst        (rst),
        .valid      (beat_valid),
        .start_addr (addr_q),
        .beat_idx   (idx),
        .down       (down_q),
        .sub        (sub_q),
        .addr       (beat_addr)
    );

    p_hold_cmd_r2: assert property (@(posedge clk) disable iff (rst)
        (busy && !beat_last) |=> ($stable(addr_q) && $stable(last_q)));
endmodule

// File: tb/dma_beat_seq_tb_top.sv
module dma_beat_seq_tb_top;
    localparam int AW = 16;
    localparam int LW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_valid = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic [LW-1:0] cmd_len = '0;
    logic          cmd_read = 1'b0;
    logic          cmd_down = 1'b0;
    logic          cmd_subblock = 1'b0;
    logic          cmd_masked = 1'b0;
    logic          busy, beat_valid, beat_start, beat_last, mask_beat;
    logic [AW-1:0] beat_addr;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    dma_beat_seq #(.ADDR_W(AW), .LEN_W(LW)) dut_i (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
        .cmd_len(cmd_len), .cmd_read(cmd_read), .cmd_down(cmd_down),
        .cmd_subblock(cmd_subblock), .cmd_masked(cmd_masked),
        .busy(busy), .beat_valid(beat_valid), .beat_addr(beat_addr),
        .beat_start(beat_start), .beat_last(beat_last), .mask_beat(mask_beat)
    );

    // {addr[15:0], len[3:0], read, down, subblock, masked}
    localparam logic [23:0] VEC [12] = '{
        {16'h0100, 4'd4,  4'b0000},
        {16'h0200, 4'd3,  4'b1100},
        {16'h0018, 4'd4,  4'b1010},
        {16'h0048, 4'd2,  4'b1110},
        {16'h0305, 4'd5,  4'b0001},
        {16'h0000, 4'd0,  4'b0000},
        {16'h0000, 4'd3,  4'b0100},
        {16'hFFF0, 4'd4,  4'b0000},
        {16'h0010, 4'd7,  4'b1010},
        {16'h0400, 4'd15, 4'b0000},
        {16'h0500, 4'd6,  4'b1001},
        {16'h0020, 4'd1,  4'b1010}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [AW-1:0] ref_addr(input logic [AW-1:0] a, input int j,
                                               input bit dn, input bit sb);
        logic [AW-4:0] w;
        w = a[AW-1:3];
        if (sb)      w = w ^ (AW-3)'(j);
        else if (dn) w = w - (AW-3)'(j);
        else         w = w + (AW-3)'(j);
        return {w, 3'b000};
    endfunction

    function automatic int ref_beats(input int len, input bit sb);
        if (sb) return (len <= 2) ? 2 : 4;
        return (len == 0) ? 1 : len;
    endfunction

    task automatic issue(input logic [AW-1:0] a, input int len, input bit rd,
                         input bit dn, input bit sb, input bit mk);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_addr = a; cmd_len = LW'(len);
        cmd_read = rd; cmd_down = dn; cmd_subblock = sb; cmd_masked = mk;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    // Called at the negedge of the first cycle after acceptance.
    task automatic check_burst(input logic [AW-1:0] a, input int len, input bit rd,
                               input bit dn, input bit sb, input bit mk);
        int nb;
        string tag;
        nb  = ref_beats(len, sb);
        tag = sb ? "R5" : (dn ? "R4" : "R3");
        if (mk && !rd) begin
            chk(mask_beat == 1'b1, "R8 mask cycle", 32'(mask_beat), 1);
            chk(beat_valid == 1'b0, "R8 no data in mask cycle", 32'(beat_valid), 0);
            @(negedge clk);
        end else begin
            chk(mask_beat == 1'b0, "R8 no mask cycle", 32'(mask_beat), 0);
        end
        for (int j = 0; j < nb; j++) begin
            chk(beat_valid == 1'b1, "R3 beat valid", 32'(beat_valid), 1);
            chk(beat_addr == ref_addr(a, j, dn, sb), tag, 32'(beat_addr),
                32'(ref_addr(a, j, dn, sb)));
            chk(beat_start == (j == 0), "R7 start", 32'(beat_start), 32'(j == 0));
            chk(beat_last == (j == nb - 1), "R7 last", 32'(beat_last), 32'(j == nb - 1));
            chk(busy == 1'b1, "R9 busy during burst", 32'(busy), 1);
            chk(mask_beat == 1'b0, "R8 mask low in data", 32'(mask_beat), 0);
            @(negedge clk);
        end
        chk(beat_valid == 1'b0, "R6 beat count", 32'(beat_valid), 0);
        chk(busy == 1'b0, "R9 busy drops", 32'(busy), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: state held in reset
        chk({busy, beat_valid, beat_start, beat_last, mask_beat} == 5'b0,
            "R1 reset outputs", 32'({busy, beat_valid, beat_start, beat_last, mask_beat}), 0);
        rst = 1'b0;

        for (int v = 0; v < 12; v++) begin
            issue(VEC[v][23:8], int'(VEC[v][7:4]), VEC[v][3], VEC[v][2], VEC[v][1], VEC[v][0]);
            check_burst(VEC[v][23:8], int'(VEC[v][7:4]), VEC[v][3], VEC[v][2],
                        VEC[v][1], VEC[v][0]);
        end

        // R2: command during busy is ignored
        issue(16'h0800, 4, 1'b0, 1'b0, 1'b0, 1'b0);
        chk(beat_addr == 16'h0800, "R2 beat0", 32'(beat_addr), 32'h0800);
        cmd_valid = 1'b1; cmd_addr = 16'h0F00; cmd_len = 4'd1; cmd_down = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(beat_addr == 16'h0808, "R2 beat1 unchanged", 32'(beat_addr), 32'h0808);
        @(negedge clk);
        chk(beat_addr == 16'h0810, "R2 beat2 unchanged", 32'(beat_addr), 32'h0810);
        @(negedge clk);
        chk(beat_last == 1'b1, "R2 length unchanged", 32'(beat_last), 1);
        @(negedge clk);
        chk(busy == 1'b0, "R2 no extra burst", 32'(busy), 0);
        @(negedge clk);
        chk(busy == 1'b0 && beat_valid == 1'b0, "R2 still idle", 32'(busy), 0);

        // R9: back-to-back acceptance in the cycle busy drops
        issue(16'h0040, 2, 1'b1, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        chk(beat_last == 1'b1, "R9 first burst last", 32'(beat_last), 1);
        cmd_valid = 1'b1; cmd_addr = 16'h0090; cmd_len = 4'd2; cmd_down = 1'b1;
        cmd_subblock = 1'b0; cmd_read = 1'b1; cmd_masked = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0, "R9 idle gap", 32'(busy), 0);
        @(negedge clk);
        cmd_valid = 1'b0;
        check_burst(16'h0090, 2, 1'b1, 1'b1, 1'b0, 1'b0);

        // R1: reset in the middle of a masked burst
        issue(16'h0A00, 8, 1'b0, 1'b0, 1'b0, 1'b1);
        @(negedge clk);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk({busy, beat_valid, beat_start, beat_last, mask_beat} == 5'b0,
            "R1 mid-burst reset", 32'({busy, beat_valid, beat_start, beat_last, mask_beat}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0, "R1 stays idle", 32'(busy), 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule